// File: doc/BRIEF.md
# Dual-Format SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A rate control word holds two divider fields and a format bit that picks one of them. In the power-of-two format a small exponent field gives coarse steps. In the linear format a wider field gives an even division that can be set in steps of two. The block drives a serial clock level and a one-cycle strobe that marks every edge of that clock, so a shift engine can sample or launch data on the strobe.

A transfer-active input starts the divider. While that input is low the count is cleared, the serial clock rests at the idle level given by a polarity input, and the rate word is loaded on every cycle. While a transfer runs, a new rate word is taken only when a half-period ends. This means no clock phase is ever cut short. Choosing the field values for a target frequency is left to software.

Top module: `spi_clkdiv`

## Requirements
- R1: The rate word `rate_ctrl_i` is 13 bits wide. Bit 12 selects the format, bits 11:8 hold the exponent E, and bits 7:0 hold the linear value N. With bit 12 clear the serial clock period is 2^(E+1) module clocks, a half-period of 2^E, and N has no effect.
- R2: With bit 12 set the serial clock period is 2*(N+1) module clocks, a half-period of N+1, and E has no effect.
- R3: The smallest division is 2. With E=0 in power-of-two format, or N=0 in linear format, `sclk_o` changes on every module clock and `tick_o` stays high while enabled.
- R4: Whenever `enable_i` is sampled low at a clock edge, the next cycle has `sclk_o` equal to `cpol_i` and `tick_o` low. During reset, `sclk_o` also equals `cpol_i` and `tick_o` is low.
- R5: After `enable_i` rises, the first change of `sclk_o` comes exactly one half-period (H module clock edges) after the first edge that sees `enable_i` high. Each later change follows the one before it by H edges.
- R6: A rate word is taken while the divider is idle, or at the edge that ends a half-period. A change in the middle of a half-period leaves that half-period's length as it was, and the new value governs the next half-period.
- R7: `tick_o` is high for exactly those cycles that follow an edge at which `sclk_o` changed level while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Transfer active; low holds the divider idle |
| cpol_i | input | 1 | Idle level of the serial clock |
| rate_ctrl_i | input | 13 | Format bit [12], exponent [11:8], linear value [7:0] |
| sclk_o | output | 1 | Serial clock level |
| tick_o | output | 1 | One-cycle strobe for each serial clock edge |

## Verification
The embedded assertions check the following on every cycle. The idle output level follows any low enable. The counter never passes the latched terminal value. The latched terminal value does not move while a half-period is in progress. The strobe appears in exactly the cycles where the internal phase flipped. Only the bench scenarios can show the absolute division ratios of each format, that the field of the unselected format is ignored, the minimum division of two, and the exact cycle in which a rate word changed mid-period takes effect. The bench checks these by counting module clocks between strobes.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

   typedef enum logic {
      FMT_POW2   = 1'b0,
      FMT_LINEAR = 1'b1
   } div_fmt_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Bits needed for the largest terminal count (half-period minus one).
   function automatic int term_width(input int exp_w, input int lin_w);
      return max_int((1 << exp_w) - 1, lin_w);
   endfunction

endpackage

// File: rtl/spi_clkdiv_decode.sv
module spi_clkdiv_decode
   import spi_clkdiv_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int LIN_W = 8,
   parameter int CNT_W = term_width(EXP_W, LIN_W)
) (
   input  logic [EXP_W-1:0] exp_f_i,
   input  logic [LIN_W-1:0] lin_f_i,
   input  div_fmt_e         fmt_i,
   output logic [CNT_W-1:0] term_o
);

   logic [CNT_W-1:0] pow2_term;
   logic [CNT_W-1:0] lin_term;

   // Power-of-two half-period 2^E minus one: the low E bits set.
   for (genvar i = 0; i < CNT_W; i++) begin : g_pow2_bit
      if (i < (1 << EXP_W) - 1) begin : g_reach
         assign pow2_term[i] = (exp_f_i > EXP_W'(i));
      end else begin : g_beyond
         assign pow2_term[i] = 1'b0;
      end
   end

   // Linear half-period N+1 minus one is N itself.
   assign lin_term = CNT_W'(lin_f_i);

   always_comb begin
      unique case (fmt_i)
         FMT_LINEAR: term_o = lin_term;
         default:    term_o = pow2_term;
      endcase
   end

endmodule

// File: rtl/spi_clkdiv_count.sv
module spi_clkdiv_count #(
   parameter int CNT_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] term_next_i,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur_term_q;

   assign wrap_o = enable_i && (cnt_q == cur_term_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         cur_term_q <= '0;
      end else if (!enable_i || wrap_o) begin
         cnt_q      <= '0;
         cur_term_q <= term_next_i;
      end else begin
         cnt_q      <= cnt_q + CNT_W'(1);
      end
   end

   AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (cnt_q == '0)); // R4

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= cur_term_q); // R5

   AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0) |-> $stable(cur_term_q)); // R6

endmodule

// File: rtl/spi_clkdiv_phase.sv
module spi_clkdiv_phase (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic wrap_i,
   output logic phase_o,
   output logic tick_o
);

   logic phase_q;
   logic tick_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= 1'b0;
         tick_q  <= 1'b0;
      end else if (!enable_i) begin
         phase_q <= 1'b0;
         tick_q  <= 1'b0;
      end else begin
         tick_q  <= wrap_i;
         if (wrap_i) begin
            phase_q <= ~phase_q;
         end
      end
   end

   assign phase_o = phase_q;
   assign tick_o  = tick_q;

   AST_TICK_MARKS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_q |-> (phase_q != $past(phase_q))); // R7

   AST_NO_TICK_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(enable_i) && !tick_q) |-> $stable(phase_q)); // R7

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
   import spi_clkdiv_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int LIN_W = 8,
   localparam int SEL_BIT = EXP_W + LIN_W,
   localparam int CTRL_W  = SEL_BIT + 1,
   localparam int CNT_W   = term_width(EXP_W, LIN_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic              cpol_i,
   input  logic [CTRL_W-1:0] rate_ctrl_i,
   output logic              sclk_o,
   output logic              tick_o
);

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp_w
      $error("spi_clkdiv: EXP_W must lie in 1..5");
   end
   if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin_w
      $error("spi_clkdiv: LIN_W must lie in 1..16");
   end

   logic [EXP_W-1:0] exp_f;
   logic [LIN_W-1:0] lin_f;
   div_fmt_e         fmt;
   logic [CNT_W-1:0] term_next;
   logic             wrap;
   logic             phase;

   assign fmt   = div_fmt_e'(rate_ctrl_i[SEL_BIT]);
   assign exp_f = rate_ctrl_i[SEL_BIT-1 -: EXP_W];
   assign lin_f = rate_ctrl_i[LIN_W-1:0];

   spi_clkdiv_decode #(
      .EXP_W (EXP_W),
      .LIN_W (LIN_W),
      .CNT_W (CNT_W)
   ) u_decode (
      .exp_f_i (exp_f),
      .lin_f_i (lin_f),
      .fmt_i   (fmt),
      .term_o  (term_next)
   );

   spi_clkdiv_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .enable_i    (enable_i),
      .term_next_i (term_next),
      .wrap_o      (wrap)
   );

   spi_clkdiv_phase u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enable_i (enable_i),
      .wrap_i   (wrap),
      .phase_o  (phase),
      .tick_o   (tick_o)
   );

   // Idle phase is zero, so the polarity input sets the resting level.
   assign sclk_o = phase ^ cpol_i;

   AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> ((sclk_o == cpol_i) && !tick_o)); // R4

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (!tick_o && (sclk_o == cpol_i))); // R4

endmodule

// File: tb/tb_spi_clkdiv.sv
module tb_spi_clkdiv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        cpol = 1'b1;
   logic [12:0] ctrl = 13'h0000;
   logic        sclk;
   logic        tick;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   spi_clkdiv dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .enable_i    (en),
      .cpol_i      (cpol),
      .rate_ctrl_i (ctrl),
      .sclk_o      (sclk),
      .tick_o      (tick)
   );

   // ctrl = {format, exponent[3:0], linear[7:0]}; expected half-period in clocks
   localparam int NVEC = 9;
   localparam logic [12:0] CTRL_TAB [NVEC] = '{
      13'h0000, // R1 R3 E=0 -> 1
      13'h01C8, // R1 E=1, linear field ignored -> 2
      13'h0300, // R1 E=3 -> 8
      13'h0F00, // R1 E=15 -> 32768
      13'h1500, // R2 R3 N=0, exponent ignored -> 1
      13'h1002, // R2 N=2 -> 3
      13'h1009, // R2 N=9 -> 10
      13'h1FFF, // R2 N=255 -> 256
      13'h0755  // R1 E=7 -> 128
   };
   localparam int HALF_TAB [NVEC] = '{1, 2, 8, 32768, 1, 3, 10, 256, 128};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Count falling edges until tick is seen high.
   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick && n < 70000);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      int n;
      // Reset state
      en = 1'b1;
      repeat (3) @(negedge clk);
      check(tick == 1'b0, "R4 reset tick", int'(tick), 0);
      check(sclk == 1'b1, "R4 reset sclk", int'(sclk), 1);
      en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         ctrl = CTRL_TAB[v];
         cpol = v[0];
         en = 1'b0;
         repeat (2) @(negedge clk);
         check(sclk == cpol && !tick, "R4 idle level", int'(sclk), int'(cpol));
         en = 1'b1;
         wait_tick(n);
         check(n == HALF_TAB[v], "R5 R1 R2 first half-period", n, HALF_TAB[v]);
         check(sclk == ~cpol, "R7 first edge level", int'(sclk), int'(~cpol));
         wait_tick(n);
         check(n == HALF_TAB[v], "R1 R2 R3 second half-period", n, HALF_TAB[v]);
         check(sclk == cpol, "R7 second edge level", int'(sclk), int'(cpol));
         if (HALF_TAB[v] > 1) begin
            @(negedge clk);
            check(tick == 1'b0, "R7 tick one cycle", int'(tick), 0);
         end
      end

      // R6: mid-period change waits for the boundary
      en = 1'b0;
      cpol = 1'b0;
      ctrl = 13'h1009;
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_tick(n);
      check(n == 10, "R6 initial half", n, 10);
      repeat (3) @(negedge clk);
      ctrl = 13'h1001;
      wait_tick(n);
      check(n == 7, "R6 old length completes", n + 3, 10);
      wait_tick(n);
      check(n == 2, "R6 new length after boundary", n, 2);

      // R4/R5: drop enable mid-period, reload while idle, restart
      en = 1'b0;
      cpol = 1'b1;
      ctrl = 13'h1004;
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_tick(n);
      check(n == 5, "R5 restart half", n, 5);
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(sclk == 1'b1, "R4 sclk after enable drop", int'(sclk), 1);
      check(tick == 1'b0, "R4 tick after enable drop", int'(tick), 0);
      ctrl = 13'h0200;
      repeat (3) @(negedge clk);
      check(sclk == 1'b1, "R4 sclk held idle", int'(sclk), 1);
      en = 1'b1;
      wait_tick(n);
      check(n == 4, "R6 R5 value loaded while idle", n, 4);
      check(sclk == 1'b0, "R5 first edge leaves idle", int'(sclk), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule